// File: doc/BRIEF.md
# T1 Loopback Code Inserter

This block sits in the transmit path of a DS1 line, after the framer and before line coding. It receives a serial stream of line bits. Each bit comes with a flag that marks the overhead (framing) slot that opens every 193-bit frame. The block can replace that stream with an in-band loopback code or with an all-ones alarm. Two code generators run side by side. The loop-up generator repeats a five-bit word and the loop-down generator repeats a three-bit word; each word is leading zeros followed by a single one.

The code can be inserted framed or unframed. In framed insertion the overhead slot carries the incoming bit and the code pauses over it. In unframed insertion the code runs over every slot. A separate override keeps the incoming overhead bit in its slot over any alarm pattern. Control inputs take effect only at the overhead slot, so a frame is never split between two patterns.

Both stream sides use valid/ready. An input bit is taken when `s_valid` and `s_ready` are both high. `s_ready` is high whenever the single output register is empty or is being emptied in the same cycle. An output bit that has been offered stays unchanged until `m_ready` takes it. The control pins are plain levels.

Top module: `t1_loopcode_inserter`

## Requirements
- R1: With loop-up selected, successive code slots carry 0,0,0,0,1 repeating.
- R2: With loop-down selected, successive code slots carry 0,0,1 repeating.
- R3: In framed insertion (`framed_en`=1) the overhead slot carries the input bit unchanged. The code sequence does not advance on that slot.
- R4: With all-ones selected and no override, every output bit is 1. This holds in overhead slots too, whatever `framed_en` is.
- R5: In unframed insertion without override, the code advances on every slot, overhead slots included, and the code bit is sent there.
- R6: Selection priority is all-ones, then loop-up, then loop-down.
- R7: With `ovh_override`=1 and any alarm pattern active, each overhead slot carries the input bit. In unframed insertion the code keeps advancing underneath the overlaid slot.
- R8: With no alarm pattern selected, each output bit equals the input bit.
- R9: Each accepted input bit appears at the output one cycle later. `s_ready` = !`m_valid` | `m_ready`. While `m_valid`=1 and `m_ready`=0, `m_bit` holds. After reset `m_valid`=0.
- R10: Control pins are sampled only when an input bit with `s_ovh`=1 is accepted. Changes at any other time have no effect until the next overhead slot. After reset the block passes data through until the first overhead slot is accepted.
- R11: When a loop code is newly selected at an overhead slot (it was not selected in the frame before), its sequence restarts at the first leading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input bit valid |
| s_ready | output | 1 | Block can accept an input bit |
| s_bit | input | 1 | Input line bit |
| s_ovh | input | 1 | Input bit is the overhead slot of a frame |
| ones_en | input | 1 | Request all-ones alarm |
| loop_up_en | input | 1 | Request loop-up code |
| loop_dn_en | input | 1 | Request loop-down code |
| framed_en | input | 1 | 1 = framed code insertion, 0 = unframed |
| ovh_override | input | 1 | Keep overhead slots over any alarm pattern |
| m_valid | output | 1 | Output bit valid |
| m_ready | input | 1 | Downstream accepts the output bit |
| m_bit | output | 1 | Output line bit |

## Verification
The hardest case to reach is a control change that arrives in the middle of a frame. The block must ignore it until the next overhead slot, and back-pressure may be stalling that slot at the same moment. The stimulus raises a loop request at a fixed payload position in a passing frame. It also raises all-ones before the first overhead slot after reset. Both ready signals are throttled at random throughout, so overhead slots are often accepted only after several stalled cycles. A second case is restarting a code after it has been away for one frame. A loop-up, loop-down, loop-up sequence, run in framed and unframed modes, shows that the code resumes at its leading zeros.

// File: rtl/t1lb_pkg.sv
package t1lb_pkg;
  typedef enum logic [1:0] {
    MODE_PASS = 2'd0,
    MODE_ONES = 2'd1,
    MODE_UP   = 2'd2,
    MODE_DOWN = 2'd3
  } lb_mode_e;

  localparam int NUM_GEN = 2;
  localparam int GEN_UP  = 0;
  localparam int GEN_DN  = 1;
endpackage

// File: rtl/t1lb_ctrl.sv
module t1lb_ctrl
  import t1lb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     beat,
  input  logic     ovh,
  input  logic     ones_req,
  input  logic     up_req,
  input  logic     dn_req,
  input  logic     framed_req,
  input  logic     ovr_req,
  output lb_mode_e mode_eff,
  output lb_mode_e mode_q,
  output logic     framed_eff,
  output logic     ovr_eff,
  output logic     restart_up,
  output logic     restart_dn
);
  lb_mode_e fresh;
  logic     framed_q, ovr_q;
  logic     boundary;

  assign boundary = beat && ovh;

  // fixed priority: all-ones, then loop-up, then loop-down
  always_comb begin
    if (ones_req)    fresh = MODE_ONES;
    else if (up_req) fresh = MODE_UP;
    else if (dn_req) fresh = MODE_DOWN;
    else             fresh = MODE_PASS;
  end

  always_comb begin
    mode_eff   = boundary ? fresh      : mode_q;
    framed_eff = boundary ? framed_req : framed_q;
    ovr_eff    = boundary ? ovr_req    : ovr_q;
    restart_up = boundary && (fresh == MODE_UP)   && (mode_q != MODE_UP);
    restart_dn = boundary && (fresh == MODE_DOWN) && (mode_q != MODE_DOWN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= MODE_PASS;
      framed_q <= 1'b0;
      ovr_q    <= 1'b0;
    end else if (boundary) begin
      mode_q   <= fresh;
      framed_q <= framed_req;
      ovr_q    <= ovr_req;
    end
  end
endmodule

// File: rtl/t1lb_codegen.sv
module t1lb_codegen #(
  parameter int LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic restart,
  input  logic adv,
  output logic code_bit
);
  localparam int W = (LEN > 1) ? $clog2(LEN) : 1;
  localparam logic [W-1:0] LAST = W'(LEN - 1);

  logic [W-1:0] idx, idx_eff;

  assign idx_eff  = restart ? '0 : idx;
  // leading zeros, closing one
  assign code_bit = (idx_eff == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
    end else if (fire) begin
      if (adv) idx <= (idx_eff == LAST) ? '0 : idx_eff + 1'b1;
      else     idx <= idx_eff;
    end
  end
endmodule

// File: rtl/t1_loopcode_inserter.sv
module t1_loopcode_inserter
  import t1lb_pkg::*;
#(
  parameter int UP_LEN = 5,
  parameter int DN_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  input  logic s_bit,
  input  logic s_ovh,
  input  logic ones_en,
  input  logic loop_up_en,
  input  logic loop_dn_en,
  input  logic framed_en,
  input  logic ovh_override,
  output logic m_valid,
  input  logic m_ready,
  output logic m_bit
);
  logic     beat;
  lb_mode_e mode_eff, mode_q;
  logic     framed_eff, ovr_eff;
  logic     restart_up, restart_dn;
  logic [NUM_GEN-1:0] fire_vec, restart_vec, code_vec;
  logic     adv, keep_code, keep_ones, nxt_bit;

  assign s_ready = !m_valid || m_ready;
  assign beat    = s_valid && s_ready;

  t1lb_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .beat       (beat),
    .ovh        (s_ovh),
    .ones_req   (ones_en),
    .up_req     (loop_up_en),
    .dn_req     (loop_dn_en),
    .framed_req (framed_en),
    .ovr_req    (ovh_override),
    .mode_eff   (mode_eff),
    .mode_q     (mode_q),
    .framed_eff (framed_eff),
    .ovr_eff    (ovr_eff),
    .restart_up (restart_up),
    .restart_dn (restart_dn)
  );

  assign restart_vec[GEN_UP] = restart_up;
  assign restart_vec[GEN_DN] = restart_dn;
  assign fire_vec[GEN_UP]    = beat && (mode_eff == MODE_UP);
  assign fire_vec[GEN_DN]    = beat && (mode_eff == MODE_DOWN);

  // framed insertion pauses the code over the overhead slot
  assign adv = !(s_ovh && framed_eff);

  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    localparam int GLEN = (g == GEN_UP) ? UP_LEN : DN_LEN;
    t1lb_codegen #(.LEN(GLEN)) u_gen (
      .clk      (clk),
      .rst_n    (rst_n),
      .fire     (fire_vec[g]),
      .restart  (restart_vec[g]),
      .adv      (adv),
      .code_bit (code_vec[g])
    );
  end

  assign keep_ones = s_ovh && ovr_eff;
  assign keep_code = s_ovh && (ovr_eff || framed_eff);

  always_comb begin
    unique case (mode_eff)
      MODE_ONES: nxt_bit = keep_ones ? s_bit : 1'b1;
      MODE_UP:   nxt_bit = keep_code ? s_bit : code_vec[GEN_UP];
      MODE_DOWN: nxt_bit = keep_code ? s_bit : code_vec[GEN_DN];
      default:   nxt_bit = s_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_bit   <= 1'b0;
    end else if (beat) begin
      m_valid <= 1'b1;
      m_bit   <= nxt_bit;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/t1lb_chk.sv
module t1lb_chk
  import t1lb_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     s_valid,
  input logic     s_ready,
  input logic     s_bit,
  input logic     s_ovh,
  input logic     m_valid,
  input logic     m_ready,
  input logic     m_bit,
  input lb_mode_e mode_eff,
  input lb_mode_e mode_q,
  input logic     ovr_eff,
  input logic [1:0] fire_vec
);
  logic beat;
  assign beat = s_valid && s_ready;

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_bit)));

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> m_valid);

  p_all_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && mode_eff == MODE_ONES && !(s_ovh && ovr_eff)) |=> (m_bit == 1'b1));

  p_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && mode_eff == MODE_PASS) |=> (m_bit == $past(s_bit)));

  p_overlay_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && s_ovh && ovr_eff && mode_eff != MODE_PASS) |=> (m_bit == $past(s_bit)));

  p_ctrl_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat && s_ovh) |=> $stable(mode_q));

  p_one_gen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fire_vec));
endmodule

bind t1_loopcode_inserter t1lb_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .s_valid  (s_valid),
  .s_ready  (s_ready),
  .s_bit    (s_bit),
  .s_ovh    (s_ovh),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_bit    (m_bit),
  .mode_eff (mode_eff),
  .mode_q   (mode_q),
  .ovr_eff  (ovr_eff),
  .fire_vec (fire_vec)
);

// File: tb/t1_loopcode_inserter_tb_top.sv
`timescale 1ns/1ps
module t1_loopcode_inserter_tb_top;
  localparam int FRAME = 193;
  localparam int UPL   = 5;
  localparam int DNL   = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_bit = 1'b0, s_ovh = 1'b0;
  logic ones_en = 1'b0, loop_up_en = 1'b0, loop_dn_en = 1'b0;
  logic framed_en = 1'b0, ovh_override = 1'b0;
  logic m_ready = 1'b0;
  logic s_ready, m_valid, m_bit;

  always #2 clk = ~clk;

  t1_loopcode_inserter dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_bit(s_bit), .s_ovh(s_ovh), .ones_en(ones_en), .loop_up_en(loop_up_en),
    .loop_dn_en(loop_dn_en), .framed_en(framed_en), .ovh_override(ovh_override),
    .m_valid(m_valid), .m_ready(m_ready), .m_bit(m_bit)
  );

  typedef struct { logic b; string tag; } exp_t;
  exp_t sb_q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 0;
  string cur_tag = "R8";

  // reference state: 0 pass, 1 ones, 2 up, 3 down
  int   ref_mode = 0;
  logic ref_fr = 0, ref_ov = 0;
  int   up_idx = 0, dn_idx = 0;

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  task automatic model_push(input logic b, input logic ovh);
    exp_t e;
    bit ru, rd, keep;
    int nm;
    ru = 0; rd = 0;
    if (ovh) begin
      nm = ones_en ? 1 : loop_up_en ? 2 : loop_dn_en ? 3 : 0;
      ru = (nm == 2) && (ref_mode != 2);
      rd = (nm == 3) && (ref_mode != 3);
      ref_mode = nm; ref_fr = framed_en; ref_ov = ovh_override;
    end
    keep = ovh && (ref_fr || ref_ov);
    case (ref_mode)
      1: e.b = (ovh && ref_ov) ? b : 1'b1;
      2: begin
        if (ru) up_idx = 0;
        e.b = keep ? b : logic'(up_idx == UPL - 1);
        if (!(ovh && ref_fr)) up_idx = (up_idx + 1) % UPL;
      end
      3: begin
        if (rd) dn_idx = 0;
        e.b = keep ? b : logic'(dn_idx == DNL - 1);
        if (!(ovh && ref_fr)) dn_idx = (dn_idx + 1) % DNL;
      end
      default: e.b = b;
    endcase
    e.tag = cur_tag;
    sb_q.push_back(e);
  endtask

  task automatic send_bit(input logic b, input logic ovh);
    bit taken = 0;
    while (!taken) begin
      @(negedge clk);
      s_valid = ($urandom_range(0, 3) != 0);
      s_bit = b; s_ovh = ovh;
      #1;
      if (s_valid && s_ready) begin
        model_push(b, ovh);
        taken = 1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic run_frames(input int nf, input string tag);
    cur_tag = tag;
    for (int f = 0; f < nf; f++)
      for (int p = 0; p < FRAME; p++)
        send_bit(logic'($urandom_range(0, 1)), p == 0);
  endtask

  task automatic set_ctl(input logic on, input logic up, input logic dn,
                         input logic fr, input logic ov);
    ones_en = on; loop_up_en = up; loop_dn_en = dn; framed_en = fr; ovh_override = ov;
  endtask

  // monitor: pops the scoreboard on every output handshake
  logic stall_prev = 0;
  logic held_bit = 0;
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      m_ready = ($urandom_range(0, 3) != 0);
      #1;
      if (rst_n && m_valid) begin
        if (stall_prev) begin
          n_vec++;
          if (m_bit !== held_bit) begin
            n_bad++;
            $display("FAIL R9 stalled output changed: actual %b expected %b", m_bit, held_bit);
          end
        end
        if (m_ready) begin
          n_vec++;
          if (sb_q.size() == 0) begin
            n_bad++;
            $display("FAIL R9 unexpected output: actual %b expected none", m_bit);
          end else begin
            e = sb_q.pop_front();
            if (m_bit !== e.b) begin
              n_bad++;
              $display("FAIL %s output bit: actual %b expected %b", e.tag, m_bit, e.b);
            end
          end
        end
        stall_prev = !m_ready;
        held_bit   = m_bit;
      end else begin
        stall_prev = 0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    n_vec++;
    if (m_valid !== 1'b0 || s_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R9 reset state: actual m_valid=%b s_ready=%b expected 0 1", m_valid, s_ready);
    end

    // R10: all-ones requested before the first overhead slot must not act yet
    set_ctl(1, 0, 0, 0, 0);
    cur_tag = "R10";
    for (int p = 1; p < 40; p++) send_bit(logic'($urandom_range(0, 1)), 1'b0);
    set_ctl(0, 0, 0, 0, 0);
    run_frames(2, "R8");
    set_ctl(0, 1, 0, 1, 0); run_frames(3, "R1_R3");
    set_ctl(0, 0, 1, 1, 0); run_frames(3, "R2_R3");
    set_ctl(0, 1, 0, 0, 0); run_frames(2, "R5");
    set_ctl(0, 0, 1, 0, 0); run_frames(2, "R5");
    set_ctl(1, 0, 0, 1, 0); run_frames(2, "R4");
    set_ctl(1, 0, 0, 0, 1); run_frames(2, "R7");
    set_ctl(0, 1, 0, 0, 1); run_frames(2, "R7");
    set_ctl(0, 0, 1, 0, 1); run_frames(2, "R7");
    set_ctl(1, 1, 1, 0, 0); run_frames(1, "R6");
    set_ctl(0, 1, 1, 1, 0); run_frames(2, "R6");
    set_ctl(0, 0, 0, 0, 0); run_frames(1, "R8");

    // R10: request arrives mid-frame, takes effect at the next overhead slot
    cur_tag = "R10";
    for (int p = 0; p < FRAME; p++) begin
      if (p == 50) set_ctl(0, 1, 0, 1, 0);
      send_bit(logic'($urandom_range(0, 1)), p == 0);
    end
    run_frames(1, "R10");

    // R11: codes restart after being deselected
    set_ctl(0, 0, 1, 1, 0); run_frames(1, "R11");
    set_ctl(0, 1, 0, 1, 0); run_frames(1, "R11");
    set_ctl(0, 0, 1, 0, 0); run_frames(1, "R11");
    set_ctl(0, 1, 0, 0, 0); run_frames(1, "R11");

    s_valid = 1'b0;
    while (sb_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    done = 1;
    report();
    $finish;
  end
endmodule